// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block sends bytes on a single serial line in the usual asynchronous form. Each frame is one low start bit, then 8 or 9 data bits sent least significant bit first, then one high stop bit. Between frames the line rests high. The host writes a byte into a one-entry holding register. The hardware moves that byte into a shift register as soon as the shift register is free. While one frame is on the wire, the host can therefore queue the next byte.

Two flags report where the data sits. `hold_empty` tells the host that the holding register may be written. It is also gated by a mask to form the interrupt request `tx_irq`. `shift_empty` reports that no frame is on the wire, and it has no interrupt. The flags follow a fixed timing. `hold_empty` is registered from the holding-register state, so after a write it is correct from the second cycle onward. No software clear exists; only a write lowers it.

The bit period comes from an internal reload counter with a 16-bit divisor. The port enable and the transmitter enable together gate the whole block. Dropping either one stops the frame in progress and discards the queued byte.

Top module: `dbuf_uart_tx`

## Requirements
- R1: After reset `txd` is 1, `hold_empty` is 1 and `shift_empty` is 1. With no frame in progress, `txd` stays 1.
- R2: In 8-bit mode (`nine_bit` = 0), a frame is: start bit 0, data bit 0 through data bit 7, stop bit 1. That is 10 bit periods.
- R3: In 9-bit mode (`nine_bit` = 1), a ninth data bit is sent between data bit 7 and the stop bit. Its value is `bit9_in` as sampled in the cycle the byte moves from the holding register into the shift register, not the value at the time of the write.
- R4: Every bit lasts `div_val` + 1 clock cycles.
- R5: The holding register transfers into the shift register only when no frame is in progress. The transfer takes one cycle. A byte written while the line is idle makes `txd` fall at the second rising edge after the write edge. A byte queued behind a frame starts the cycle after that frame's stop bit ends.
- R6: After a write that stays in the holding register, `hold_empty` still shows its old value in the first cycle after the write edge. It shows 0 from the second cycle on, until the transfer.
- R7: `tx_irq` equals `hold_empty` AND `irq_mask`. `hold_empty` does not depend on the mask.
- R8: `shift_empty` is 0 from the first cycle of a start bit through the last cycle of its stop bit, and 1 otherwise.
- R9: When `port_en` or `tx_en` is 0, `txd` is 1 from the next cycle, the frame in progress is dropped and `shift_empty` is 1. A queued byte is discarded, so no frame starts after re-enabling.
- R10: A write while the holding register is full replaces the queued byte. The frame being shifted is not changed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_en | input | 1 | Serial port enable |
| tx_en | input | 1 | Transmitter enable |
| div_val | input | 16 | Bit-period divisor; a bit lasts div_val+1 cycles |
| nine_bit | input | 1 | 1 selects 9 data bits |
| bit9_in | input | 1 | Ninth data bit value, sampled at transfer |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to queue |
| irq_mask | input | 1 | Interrupt mask for hold_empty |
| hold_empty | output | 1 | Holding register is free (registered) |
| shift_empty | output | 1 | No frame on the wire |
| tx_irq | output | 1 | hold_empty AND irq_mask |
| txd | output | 1 | Serial output, idle high |

## Verification
A table of frames sweeps the divisor (0, 1, 2, 3, 5), the data patterns (0xA5, 0x01, 0x3C, 0xFF, 0x80) and both frame lengths.
- Alternating and single-bit patterns show whether bits go out LSB first and in which slot each bit lands.
- The 8-bit entry with `bit9_in` high shows that the ninth slot is left out when it is not selected.

Directed sequences check the following:
- Queuing behind a running frame, and then overwriting the queue, separates the two-cycle flag lag, the overwrite rule and the "start only after the stop bit" rule.
- Changing `bit9_in` between write and transfer shows when the ninth bit is sampled.
- A mid-frame disable shows that both the frame and the queue are dropped.

// File: rtl/dbuf_uart_tx_pkg.sv
package dbuf_uart_tx_pkg;

    localparam int DATA_W  = 8;
    localparam int FRAME_W = DATA_W + 3;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    typedef enum logic {
        SH_IDLE = 1'b0,
        SH_RUN  = 1'b1
    } sh_state_t;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;
        logic [CNT_W-1:0]   nbits;
    } tx_frame_t;

    function automatic tx_frame_t build_frame(
        input logic              nine,
        input logic              b9,
        input logic [DATA_W-1:0] d
    );
        tx_frame_t f;
        f.bits  = {1'b1, (nine ? b9 : 1'b1), d, 1'b0};
        f.nbits = nine ? CNT_W'(FRAME_W) : CNT_W'(FRAME_W - 1);
        return f;
    endfunction

endpackage

// File: rtl/bit_rate_div.sv
module bit_rate_div #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div_val,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == div_val);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assert_tick_needs_run_R4: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && !$past(tick)) |-> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/tx_hold_buf.sv
module tx_hold_buf
    import dbuf_uart_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data
);
    always_ff @(posedge clk) begin
        if (rst || !active) begin
            full <= 1'b0;
            data <= '0;
        end else if (wr_en) begin
            full <= 1'b1;
            data <= wr_data;
        end else if (take) begin
            full <= 1'b0;
        end
    end

    assert_write_replaces_R10: assert property (@(posedge clk) disable iff (rst)
        (active && wr_en) |=> (full && data == $past(wr_data)));

endmodule

// File: rtl/tx_shifter.sv
module tx_shifter
    import dbuf_uart_tx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      active,
    input  logic      load,
    input  tx_frame_t frame,
    input  logic      tick,
    output logic      busy,
    output logic      txd
);
    sh_state_t          state;
    logic [FRAME_W-1:0] sr;
    logic [CNT_W-1:0]   left;

    assign busy = (state == SH_RUN);
    assign txd  = busy ? sr[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            state <= SH_IDLE;
            sr    <= '1;
            left  <= '0;
        end else if (load && !busy) begin
            state <= SH_RUN;
            sr    <= frame.bits;
            left  <= frame.nbits;
        end else if (busy && tick) begin
            sr   <= {1'b1, sr[FRAME_W-1:1]};
            left <= left - 1'b1;
            if (left == CNT_W'(1)) begin
                state <= SH_IDLE;
            end
        end
    end

    assert_start_low_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !txd);

    assert_stop_high_R2: assert property (@(posedge clk) disable iff (rst)
        (busy && left == CNT_W'(1)) |-> txd);

    assert_bit_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !$past(tick)) |-> $stable(txd));

endmodule

// File: rtl/dbuf_uart_tx.sv
module dbuf_uart_tx
    import dbuf_uart_tx_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             port_en,
    input  logic             tx_en,
    input  logic [DIV_W-1:0] div_val,
    input  logic             nine_bit,
    input  logic             bit9_in,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic             irq_mask,
    output logic             hold_empty,
    output logic             shift_empty,
    output logic             tx_irq,
    output logic             txd
);
    logic              active;
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              busy;
    logic              take;
    logic              tick;
    logic              empty_q;
    tx_frame_t         frame;

    assign active = port_en && tx_en;
    assign take   = active && hold_full && !busy;
    assign frame  = build_frame(nine_bit, bit9_in, hold_data);

    tx_hold_buf u_buf (
        .clk     (clk),
        .rst     (rst),
        .active  (active),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .take    (take),
        .full    (hold_full),
        .data    (hold_data)
    );

    bit_rate_div #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst     (rst),
        .run     (busy),
        .div_val (div_val),
        .tick    (tick)
    );

    tx_shifter u_sh (
        .clk    (clk),
        .rst    (rst),
        .active (active),
        .load   (take),
        .frame  (frame),
        .tick   (tick),
        .busy   (busy),
        .txd    (txd)
    );

    // Registered flag: correct from the second cycle after a write.
    always_ff @(posedge clk) begin
        if (rst) begin
            empty_q <= 1'b1;
        end else begin
            empty_q <= !hold_full;
        end
    end

    assign hold_empty  = empty_q;
    assign shift_empty = !busy;
    assign tx_irq      = empty_q && irq_mask;

    assert_abort_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !active |=> (txd && shift_empty));

    assert_transfer_when_idle_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(hold_full));

endmodule

// File: tb/dbuf_uart_tx_tb_top.sv
module dbuf_uart_tx_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        port_en = 1'b1;
    logic        tx_en = 1'b1;
    logic [15:0] div_val = 16'd3;
    logic        nine_bit = 1'b0;
    logic        bit9_in = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic        irq_mask = 1'b1;
    logic        hold_empty, shift_empty, tx_irq, txd;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dbuf_uart_tx dut_i (
        .clk(clk), .rst(rst), .port_en(port_en), .tx_en(tx_en),
        .div_val(div_val), .nine_bit(nine_bit), .bit9_in(bit9_in),
        .wr_en(wr_en), .wr_data(wr_data), .irq_mask(irq_mask),
        .hold_empty(hold_empty), .shift_empty(shift_empty),
        .tx_irq(tx_irq), .txd(txd)
    );

    // {nine_bit, bit9_in, data, divisor}
    localparam int NV = 5;
    localparam logic [25:0] VEC [NV] = '{
        {1'b0, 1'b0, 8'hA5, 16'd3},
        {1'b0, 1'b0, 8'h01, 16'd0},
        {1'b1, 1'b1, 8'h3C, 16'd2},
        {1'b1, 1'b0, 8'hFF, 16'd5},
        {1'b0, 1'b1, 8'h80, 16'd1}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_byte(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [11:0] exp_frame(input logic nine, input logic b9, input logic [7:0] d);
        logic [11:0] e;
        e = '0;
        e[8:1] = d;
        if (nine) begin
            e[9] = b9;
            e[10] = 1'b1;
        end else begin
            e[9] = 1'b1;
        end
        return e;
    endfunction

    task automatic get_frame(input int nb, input int per, output logic [11:0] bits, output bit ok);
        int guard = 0;
        bits = '0;
        ok = 1'b1;
        while (txd !== 1'b0 && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
        if (guard >= 3000) begin
            ok = 1'b0;
            return;
        end
        cyc(per / 2);
        for (int i = 0; i < nb + 2; i++) begin
            bits[i] = txd;
            if (i < nb + 1) cyc(per);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [11:0] got;
        bit ok;
        int nb, per, cnt;

        // Reset state
        cyc(3);
        rst = 1'b0;
        cyc(1);
        check(txd === 1'b1, "R1 idle txd", 32'(txd), 1);
        check(hold_empty === 1'b1, "R1 hold_empty", 32'(hold_empty), 1);
        check(shift_empty === 1'b1, "R8 shift_empty idle", 32'(shift_empty), 1);
        check(tx_irq === 1'b1, "R7 irq with mask set", 32'(tx_irq), 1);

        // Frame table
        for (int i = 0; i < NV; i++) begin
            nine_bit = VEC[i][25];
            bit9_in  = VEC[i][24];
            div_val  = VEC[i][15:0];
            nb  = nine_bit ? 9 : 8;
            per = int'(div_val) + 1;
            write_byte(VEC[i][23:16]);
            get_frame(nb, per, got, ok);
            check(ok && got == exp_frame(VEC[i][25], VEC[i][24], VEC[i][23:16]),
                  nine_bit ? "R3 nine-bit frame" : "R2 eight-bit frame",
                  32'(got), 32'(exp_frame(VEC[i][25], VEC[i][24], VEC[i][23:16])));
            cyc(per + 3);
            check(shift_empty === 1'b1 && txd === 1'b1, "R8 idle after frame", 32'(shift_empty), 1);
        end

        // R5 latency and R4 bit length
        nine_bit = 1'b0;
        div_val = 16'd3;
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = 8'hFF;
        @(negedge clk);
        wr_en = 1'b0;
        check(txd === 1'b1 && shift_empty === 1'b1, "R5 no start one cycle after write", 32'(txd), 1);
        @(negedge clk);
        check(txd === 1'b0, "R5 start at second edge", 32'(txd), 0);
        check(shift_empty === 1'b0, "R8 busy during start", 32'(shift_empty), 0);
        cnt = 0;
        while (txd === 1'b0 && cnt < 100) begin
            cnt++;
            @(negedge clk);
        end
        check(cnt == 4, "R4 start bit length", 32'(cnt), 4);
        cyc(50);

        // R6 lag, R7 irq, R10 overwrite, R5 queued frame
        write_byte(8'h11);
        fork
            begin
                get_frame(8, 4, got, ok);
                check(ok && got == exp_frame(1'b0, 1'b0, 8'h11), "R10 running frame untouched",
                      32'(got), 32'(exp_frame(1'b0, 1'b0, 8'h11)));
            end
            begin
                cyc(3);
                wr_en = 1'b1;
                wr_data = 8'h22;
                @(negedge clk);
                wr_en = 1'b0;
                check(hold_empty === 1'b1, "R6 stale first cycle", 32'(hold_empty), 1);
                @(negedge clk);
                check(hold_empty === 1'b0, "R6 valid second cycle", 32'(hold_empty), 0);
                check(tx_irq === 1'b0, "R7 irq low when full", 32'(tx_irq), 0);
                write_byte(8'h5A);
            end
        join
        get_frame(8, 4, got, ok);
        check(ok && got == exp_frame(1'b0, 1'b0, 8'h5A), "R10 overwritten byte sent",
              32'(got), 32'(exp_frame(1'b0, 1'b0, 8'h5A)));
        cyc(10);
        check(hold_empty === 1'b1 && tx_irq === 1'b1, "R7 irq after drain", 32'(tx_irq), 1);
        irq_mask = 1'b0;
        cyc(1);
        check(tx_irq === 1'b0 && hold_empty === 1'b1, "R7 masked irq, flag still set", 32'(tx_irq), 0);
        irq_mask = 1'b1;

        // R3 ninth bit sampled at transfer
        nine_bit = 1'b1;
        bit9_in = 1'b1;
        write_byte(8'h0F);
        fork
            begin
                get_frame(9, 4, got, ok);
            end
            begin
                cyc(3);
                write_byte(8'hC3);
                bit9_in = 1'b0;
            end
        join
        get_frame(9, 4, got, ok);
        check(ok && got == exp_frame(1'b1, 1'b0, 8'hC3), "R3 ninth bit taken at transfer",
              32'(got), 32'(exp_frame(1'b1, 1'b0, 8'hC3)));
        cyc(10);
        nine_bit = 1'b0;

        // R9 abort
        div_val = 16'd7;
        write_byte(8'h00);
        cyc(4);
        write_byte(8'h77);
        cyc(2);
        check(txd === 1'b0, "R9 frame running before disable", 32'(txd), 0);
        tx_en = 1'b0;
        @(negedge clk);
        check(txd === 1'b1 && shift_empty === 1'b1, "R9 idle after disable", 32'(txd), 1);
        @(negedge clk);
        check(hold_empty === 1'b1, "R9 queue dropped", 32'(hold_empty), 1);
        tx_en = 1'b1;
        cnt = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (txd !== 1'b1) cnt++;
        end
        check(cnt == 0, "R9 no frame after re-enable", 32'(cnt), 0);
        port_en = 1'b0;
        write_byte(8'h00);
        cyc(3);
        check(txd === 1'b1 && shift_empty === 1'b1, "R9 write ignored while port off", 32'(txd), 1);
        port_en = 1'b1;

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule